// File: doc/BRIEF.md
# Host Command Pointer Register Interface

This block sits between a host I/O bus and a tape controller's command engine. The host sees two word addresses. The first address accepts a command pointer when written and returns the low half of the current bus address when read. The second address returns a status word. A word write to the second address asks for a controller initialize. A byte write to its upper half loads a one-shot extension that holds the upper address nibble and a boot request.

A pointer write that the block accepts does four things. It scatters the data bits into a 22-bit address on a four-byte boundary, loads that address into the bus address register, clears the ready flag and issues a one-cycle start pulse to the command engine. A pointer write that arrives while the controller is busy is refused. The status word then shows the refusal. After a command has started, the DMA engine advances the bus address through two increment inputs. The command engine reports completion with a done pulse and a termination class.

Top module: `hbr_regif`

## Requirements
- R1: An accepted pointer write of data D forms the address {X, D[1:0], D[15:2], 2'b00}, where X is the upper nibble. This address is loaded into the bus address and presented on `start_ptr` during the one-cycle `start` pulse that follows the write edge.
- R2: A byte write to the status upper half while ready stores data bits 11:8 as X and data bit 15 as the boot request. It does not clear ready. The stored values are consumed by the next accepted pointer write and then cleared, so a following pointer write without a reload gives X = 0 and boot = 0.
- R3: While `ext_en` is low, X is taken as zero. The boot request still passes to `start_boot`.
- R4: An accepted pointer write clears ready (status bit 7). `start` lasts exactly one cycle.
- R5: A pointer write while ready is clear is refused. No start is issued and the bus address is unchanged. Status bit 12 (refused) and bit 15 (special condition) are set, and the termination class (bits 3:1) reads zero.
- R6: A byte write to the status upper half while ready is clear is ignored.
- R7: A word write to the status address does not load its data into the status word. It pulses `init_req` for one cycle, sets ready, and clears the refused flag, the termination class and the stored extension. The bus address is kept.
- R8: A `ctl_done` pulse sets ready and loads `ctl_term` into status bits 3:1. The refused flag keeps its value until the next accepted pointer write or initialize.
- R9: `dma_inc_word` adds 2 to the bus address and `dma_inc_byte` adds 1. When both are high in the same cycle, the word increment applies.
- R10: The status word has the following layout. Bit 15 is the special condition, equal to refused OR sanity OR nonexistent memory. Bit 13 is sanity. Bit 12 is refused. Bit 11 is nonexistent memory. Bit 10 is need-buffer. Bits 9:8 are bus address 17:16. Bit 7 is ready. Bit 6 is offline. Bits 5:4 are the fatal class. Bits 3:1 are the termination class. Bits 14 and 0 read as zero.
- R11: After reset the status word reads 16'h0080 and the bus address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host write strobe, one cycle per access |
| acc_sel | input | 1 | 0 selects the pointer/address word, 1 selects the status word |
| acc_byte_hi | input | 1 | Write is a byte write to the upper half |
| acc_wdata | input | 16 | Host write data |
| rd_data | output | 16 | Read data for the word selected by acc_sel |
| ext_en | input | 1 | Enables the upper address nibble |
| st_sanity | input | 1 | Sanity error flag from the controller |
| st_nxm | input | 1 | Nonexistent memory flag |
| st_need_buf | input | 1 | Message buffer address still needed |
| st_offline | input | 1 | Drive offline |
| st_fatal | input | 2 | Fatal class |
| ctl_done | input | 1 | Command finished pulse |
| ctl_term | input | 3 | Termination class delivered with ctl_done |
| dma_inc_word | input | 1 | Advance bus address by 2 |
| dma_inc_byte | input | 1 | Advance bus address by 1 |
| bus_addr | output | 22 | Current bus address |
| start | output | 1 | One-cycle command start |
| start_ptr | output | 22 | Command pointer during start |
| start_boot | output | 1 | Boot request during start |
| init_req | output | 1 | One-cycle controller initialize request |

## Verification
The pointer composition is tried with a data word whose low two bits are non-zero, so that a swapped or unshifted field shows up in `start_ptr`. It is tried with and without a loaded nibble and with `ext_en` both high and low, which separates the enable masking from the one-shot clearing of the extension. Refused writes and ignored byte writes are applied while busy. After each one, an accepted write exposes any state that changed when it should not have. The status layout is checked with all live flags set and then with a single flag, which catches misplaced bits and a wrong special-condition term.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int DW     = 16;
  localparam int AW     = 22;
  localparam int TW     = 3;
  localparam int XW     = AW - 18;
  localparam int FW     = 2;
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode (
  input  logic acc_valid,
  input  logic acc_sel,
  input  logic acc_byte_hi,
  output logic wr_ptr,
  output logic wr_ext,
  output logic wr_init
);
  always_comb begin
    wr_ptr  = acc_valid && !acc_sel && !acc_byte_hi;
    wr_ext  = acc_valid &&  acc_sel &&  acc_byte_hi;
    wr_init = acc_valid &&  acc_sel && !acc_byte_hi;
  end
endmodule

// File: rtl/hbr_addr_reg.sv
module hbr_addr_reg #(
  parameter int AW = hbr_pkg::AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_word,
  input  logic          inc_byte,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_nx;
  logic          addr_en;

  always_comb begin
    addr_en = load || inc_word || inc_byte;
    if (load)          addr_nx = load_val;
    else if (inc_word) addr_nx = addr + AW'(2);
    else               addr_nx = addr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_nx;
  end

  AST_INC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_word && !load) |=> (addr == $past(addr) + AW'(2))); // R9
  AST_INC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_byte && !inc_word && !load) |=> (addr == $past(addr) + AW'(1))); // R9
endmodule

// File: rtl/hbr_ctl.sv
module hbr_ctl
  import hbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ptr,
  input  logic          wr_ext,
  input  logic          wr_init,
  input  logic [DW-1:0] wdata,
  input  logic          ext_en,
  input  logic          ctl_done,
  input  logic [TW-1:0] ctl_term,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_val,
  output logic          ready,
  output logic          refused,
  output logic [TW-1:0] term,
  output logic          start,
  output logic [AW-1:0] start_ptr,
  output logic          start_boot,
  output logic          init_req
);
  logic          ready_nx, refused_nx, boot_nx, start_nx, init_nx;
  logic [TW-1:0] term_nx;
  logic [XW-1:0] ext_q, ext_nx;
  logic          boot_q;
  logic          sp_en;

  always_comb begin
    ptr_load = wr_ptr && ready;
    ptr_val  = {(ext_en ? ext_q : XW'(0)), wdata[1:0], wdata[15:2], 2'b00};
    sp_en    = ptr_load;
  end

  always_comb begin
    ready_nx   = ready;
    refused_nx = refused;
    term_nx    = term;
    ext_nx     = ext_q;
    boot_nx    = boot_q;
    start_nx   = 1'b0;
    init_nx    = 1'b0;
    if (ctl_done) begin
      ready_nx = 1'b1;
      term_nx  = ctl_term;
    end
    if (wr_init) begin
      ready_nx   = 1'b1;
      refused_nx = 1'b0;
      term_nx    = '0;
      ext_nx     = '0;
      boot_nx    = 1'b0;
      init_nx    = 1'b1;
    end else if (wr_ptr) begin
      term_nx = '0;
      if (ready) begin
        ready_nx   = 1'b0;
        refused_nx = 1'b0;
        ext_nx     = '0;
        boot_nx    = 1'b0;
        start_nx   = 1'b1;
      end else begin
        refused_nx = 1'b1;
      end
    end else if (wr_ext && ready) begin
      ext_nx  = wdata[11:8];
      boot_nx = wdata[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b1;
      refused  <= 1'b0;
      term     <= '0;
      ext_q    <= '0;
      boot_q   <= 1'b0;
      start    <= 1'b0;
      init_req <= 1'b0;
    end else begin
      ready    <= ready_nx;
      refused  <= refused_nx;
      term     <= term_nx;
      ext_q    <= ext_nx;
      boot_q   <= boot_nx;
      start    <= start_nx;
      init_req <= init_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ptr  <= '0;
      start_boot <= 1'b0;
    end else if (sp_en) begin
      start_ptr  <= ptr_val;
      start_boot <= boot_q;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R4
  AST_START_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !ready); // R4
  AST_REFUSE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refused) |-> (!start && term == '0)); // R5
  AST_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !$past(ext_en)) |-> (start_ptr[AW-1:18] == '0)); // R3
  AST_INIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |-> (ready && !refused)); // R7
endmodule

// File: rtl/hbr_regif.sv
module hbr_regif
  import hbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_sel,
  input  logic          acc_byte_hi,
  input  logic [15:0]   acc_wdata,
  output logic [15:0]   rd_data,
  input  logic          ext_en,
  input  logic          st_sanity,
  input  logic          st_nxm,
  input  logic          st_need_buf,
  input  logic          st_offline,
  input  logic [1:0]    st_fatal,
  input  logic          ctl_done,
  input  logic [2:0]    ctl_term,
  input  logic          dma_inc_word,
  input  logic          dma_inc_byte,
  output logic [21:0]   bus_addr,
  output logic          start,
  output logic [21:0]   start_ptr,
  output logic          start_boot,
  output logic          init_req
);
  logic          wr_ptr, wr_ext, wr_init;
  logic          ptr_load, ready, refused;
  logic [AW-1:0] ptr_val;
  logic [TW-1:0] term;
  logic [DW-1:0] status;

  hbr_decode u_dec (
    .acc_valid   (acc_valid),
    .acc_sel     (acc_sel),
    .acc_byte_hi (acc_byte_hi),
    .wr_ptr      (wr_ptr),
    .wr_ext      (wr_ext),
    .wr_init     (wr_init)
  );

  hbr_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ptr     (wr_ptr),
    .wr_ext     (wr_ext),
    .wr_init    (wr_init),
    .wdata      (acc_wdata),
    .ext_en     (ext_en),
    .ctl_done   (ctl_done),
    .ctl_term   (ctl_term),
    .ptr_load   (ptr_load),
    .ptr_val    (ptr_val),
    .ready      (ready),
    .refused    (refused),
    .term       (term),
    .start      (start),
    .start_ptr  (start_ptr),
    .start_boot (start_boot),
    .init_req   (init_req)
  );

  hbr_addr_reg #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .inc_word (dma_inc_word),
    .inc_byte (dma_inc_byte),
    .addr     (bus_addr)
  );

  always_comb begin
    status = {refused || st_sanity || st_nxm, 1'b0, st_sanity, refused,
              st_nxm, st_need_buf, bus_addr[17:16], ready, st_offline,
              st_fatal, term, 1'b0};
    rd_data = acc_sel ? status : bus_addr[15:0];
  end

  AST_START_PTR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (start_ptr == bus_addr)); // R1
  AST_REFUSED_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr && !ready && !dma_inc_word && !dma_inc_byte) |=> $stable(bus_addr)); // R5
endmodule

// File: tb/test_hbr_regif.sv
`timescale 1ns/1ps
module test_hbr_regif;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_sel, acc_byte_hi;
  logic [15:0] acc_wdata, rd_data;
  logic        ext_en, st_sanity, st_nxm, st_need_buf, st_offline;
  logic [1:0]  st_fatal;
  logic        ctl_done;
  logic [2:0]  ctl_term;
  logic        dma_inc_word, dma_inc_byte;
  logic [21:0] bus_addr, start_ptr;
  logic        start, start_boot, init_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hbr_regif i_hbr_regif (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
    .acc_byte_hi(acc_byte_hi), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .ext_en(ext_en), .st_sanity(st_sanity), .st_nxm(st_nxm),
    .st_need_buf(st_need_buf), .st_offline(st_offline), .st_fatal(st_fatal),
    .ctl_done(ctl_done), .ctl_term(ctl_term), .dma_inc_word(dma_inc_word),
    .dma_inc_byte(dma_inc_byte), .bus_addr(bus_addr), .start(start),
    .start_ptr(start_ptr), .start_boot(start_boot), .init_req(init_req)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] compose(input logic [3:0] x, input logic [15:0] d);
    return {x, d[1:0], d[15:2], 2'b00};
  endfunction

  // write: drive for one cycle; on return the edge has happened and pulses are visible
  task automatic wr(input logic sel, input logic bhi, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_sel = sel; acc_byte_hi = bhi; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_byte_hi = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    acc_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic done(input logic [2:0] t);
    @(negedge clk);
    ctl_done = 1'b1; ctl_term = t;
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(1'b1, v); chk("R11", "status after reset", v, 16'h0080);
    rd(1'b0, v); chk("R11", "bus addr after reset", v, 16'h0000);
    chk("R11", "start idle", start, 1'b0);
  endtask

  task automatic t_ptr_basic;
    logic [15:0] v;
    wr(1'b0, 1'b0, 16'hABCD);
    chk("R4", "start pulse", start, 1'b1);
    chk("R1", "start_ptr", start_ptr, compose(4'h0, 16'hABCD));
    chk("R1", "bus_addr", bus_addr, 22'h01ABCC);
    rd(1'b1, v); chk("R10", "status busy addr17:16", v, 16'h0100);
    @(negedge clk);
    chk("R4", "start one cycle", start, 1'b0);
  endtask

  task automatic t_refused;
    logic [15:0] v;
    wr(1'b0, 1'b0, 16'h1234);
    chk("R5", "no start when busy", start, 1'b0);
    rd(1'b1, v); chk("R5", "refused status", v, 16'h9100);
    rd(1'b0, v); chk("R5", "bus addr kept", v, 16'hABCC);
  endtask

  task automatic t_ext_busy_then_done;
    logic [15:0] v;
    wr(1'b1, 1'b1, 16'h8F00);            // ignored: not ready (R6)
    done(3'd5);
    rd(1'b1, v); chk("R8", "done status", v, 16'h918A);
    wr(1'b0, 1'b0, 16'h0004);
    chk("R6", "busy ext ignored ptr", start_ptr, 22'h000004);
    chk("R6", "busy ext ignored boot", start_boot, 1'b0);
    rd(1'b1, v); chk("R5", "refused cleared by accept", v, 16'h0000);
  endtask

  task automatic t_ext_load;
    logic [15:0] v;
    done(3'd0);
    wr(1'b1, 1'b1, 16'h8500);
    rd(1'b1, v); chk("R2", "ext write keeps ready", v[7], 1'b1);
    wr(1'b0, 1'b0, 16'h0010);
    chk("R2", "ptr with nibble", start_ptr, compose(4'h5, 16'h0010));
    chk("R2", "boot passed", start_boot, 1'b1);
    done(3'd0);
    wr(1'b0, 1'b0, 16'h0010);
    chk("R2", "nibble consumed", start_ptr, 22'h000010);
    chk("R2", "boot consumed", start_boot, 1'b0);
  endtask

  task automatic t_ext_off;
    done(3'd0);
    ext_en = 1'b0;
    wr(1'b1, 1'b1, 16'h8A00);
    wr(1'b0, 1'b0, 16'h0020);
    chk("R3", "nibble masked", start_ptr, 22'h000020);
    chk("R3", "boot still seen", start_boot, 1'b1);
    ext_en = 1'b1;
  endtask

  task automatic t_dma;
    @(negedge clk); dma_inc_word = 1'b1;
    @(negedge clk); dma_inc_word = 1'b0;
    chk("R9", "word inc", bus_addr, 22'h000022);
    dma_inc_byte = 1'b1;
    @(negedge clk); dma_inc_byte = 1'b0;
    chk("R9", "byte inc", bus_addr, 22'h000023);
    dma_inc_byte = 1'b1; dma_inc_word = 1'b1;
    @(negedge clk); dma_inc_byte = 1'b0; dma_inc_word = 1'b0;
    chk("R9", "word wins", bus_addr, 22'h000025);
  endtask

  task automatic t_init;
    logic [15:0] v;
    done(3'd0);
    wr(1'b1, 1'b1, 16'h8300);
    wr(1'b0, 1'b0, 16'h0000);            // busy again so refuse next
    wr(1'b0, 1'b0, 16'h0000);
    wr(1'b1, 1'b0, 16'hFFFF);
    chk("R7", "init pulse", init_req, 1'b1);
    rd(1'b1, v); chk("R7", "status after init", v, 16'h0080);
    rd(1'b0, v); chk("R7", "bus addr kept", v, 16'h0000);
    @(negedge clk);
    chk("R7", "init one cycle", init_req, 1'b0);
    wr(1'b1, 1'b1, 16'h8300);
    wr(1'b1, 1'b0, 16'h0000);
    wr(1'b0, 1'b0, 16'h0040);
    chk("R7", "init cleared ext", start_ptr, 22'h000040);
    chk("R7", "init cleared boot", start_boot, 1'b0);
  endtask

  task automatic t_layout;
    logic [15:0] v;
    st_sanity = 1; st_nxm = 1; st_need_buf = 1; st_offline = 1; st_fatal = 2'b11;
    rd(1'b1, v); chk("R10", "all flags", v, 16'hAC70);
    st_sanity = 0; st_nxm = 0; st_need_buf = 0; st_fatal = 2'b00;
    rd(1'b1, v); chk("R10", "offline only", v, 16'h0040);
    st_offline = 0; st_nxm = 1;
    rd(1'b1, v); chk("R10", "nxm sets special", v, 16'h8800);
    st_nxm = 0;
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 0; acc_sel = 0; acc_byte_hi = 0; acc_wdata = '0;
    ext_en = 1; st_sanity = 0; st_nxm = 0; st_need_buf = 0; st_offline = 0;
    st_fatal = '0; ctl_done = 0; ctl_term = '0; dma_inc_word = 0; dma_inc_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ptr_basic;
    t_refused;
    t_ext_busy_then_done;
    t_ext_load;
    t_ext_off;
    t_dma;
    t_init;
    t_layout;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule